// File: doc/BRIEF.md
# Grouped-Direction Digital I/O Port

This block is an eight-line general-purpose digital port. A single 16-bit control register carries the output levels, two direction bits and the edge-polarity settings. The eight lines are split into two nibbles, and each nibble is switched between input and output as a whole. Reading the control register returns the live line levels in its low byte. For a line that is driven, that level is the value the port drives.

Every line also feeds a synchronised edge detector. A detected edge on line n sets a sticky bit at position 8+n of a status register. Software clears these bits by writing ones to them. An enable register with the same bit layout selects which pending status bits reach the single interrupt request output.

The port has a simple register interface. A write strobe with an address and data commits on the clock edge. Read data is returned combinationally for the address presented. Address 0 selects the control register, address 1 the status register and address 2 the enable register. Address 3 is unused.

Top module: `dio_port`

## Requirements
- R1: A control write (address 0) loads bits 7:0 into the output latch, and pad_o shows them from the next cycle onward.
- R2: Control bit 10 set makes lines 0 to 3 outputs (pad_oe_o[3:0] all ones), and control bit 11 does the same for lines 4 to 7; a clear bit makes that nibble input.
- R3: Reading address 0 returns, in bits 7:0, the latched output value for output lines and the synchronised pad level for input lines; bits 8 and 15:10 read back as written, and bit 9 reads 0.
- R4: Control bits 12 to 15 choose the detected edge for lines 0 to 3 one by one, and control bit 8 chooses it for lines 4 to 7 together; 1 means falling edge, 0 means rising edge.
- R5: A selected edge on line n sets status bit 8+n (address 1) no later than the third rising clock edge after the pad changes; the bit then stays set until cleared, and status bits 7:0 always read 0.
- R6: Writing address 1 clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R7: When an edge event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: irq_o is high exactly when some status bit is set and its enable bit (address 2, bits 15:8) is set; enable bits 7:0 read 0.
- R9: Edge detection follows the pad input even on lines configured as outputs.
- R10: After reset, all lines are inputs, pad_o is 0, status and enable are 0, and irq_o is low.
- R11: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 status, 2 enable) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| pad_i | input | 8 | Line levels from the pads |
| pad_o | output | 8 | Output levels to the pads |
| pad_oe_o | output | 8 | Per-line output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the write strobe, address and data are settled around each clock edge. They make no assumption about pad timing, because the pads go through the synchroniser first. The stickiness and clear checks assume that status changes only through a detected event or a clearing write. The stimulus keeps every pad value stable for at least four cycles and changes it only at falling clock edges. Each change therefore produces exactly one evaluation in the detector, and the bench model can predict the status from the old level, the new level and the polarity bits. Register writes likewise change only at falling edges, apart from one directed case. That case places a clearing write on the exact cycle in which an event lands.

// File: rtl/dio_port_pkg.sv
package dio_port_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned GRP   = 4;
  localparam int unsigned NGRP  = LINES / GRP;
  localparam int unsigned RW    = 16;
  localparam int unsigned AW    = 2;
  localparam int unsigned B_EVT = 8;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_IEN  = 2'd2;

  // control layout: out[7:0], upol[8], spare[9], dir[11:10], lpol[15:12]
  typedef struct packed {
    logic [GRP-1:0]   lpol;
    logic [NGRP-1:0]  dir;
    logic             spare;
    logic             upol;
    logic [LINES-1:0] out;
  } ctrl_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dio_edge.sv
module dio_edge #(
  parameter int unsigned W      = 8,
  parameter int unsigned SETTLE = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] evt_o
);
  localparam int unsigned CW = $clog2(SETTLE + 1);

  logic [W-1:0]  prev_q;
  logic [W-1:0]  evt_raw;
  logic [CW-1:0] cnt_q;
  logic          armed;

  // mask the level present at reset release until prev holds a real sample
  assign armed = (cnt_q == CW'(SETTLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      if (!armed) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    assign evt_raw[i] = fall_i[i] ? (prev_q[i] & ~lvl_i[i])
                                  : (~prev_q[i] & lvl_i[i]);
  end

  assign evt_o = armed ? evt_raw : '0;
endmodule

// File: rtl/dio_irq.sv
module dio_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;

  // new event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | evt_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en_i);
endmodule

// File: rtl/dio_port.sv
module dio_port
  import dio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  input  logic [LINES-1:0] pad_i,
  output logic [LINES-1:0] pad_o,
  output logic [LINES-1:0] pad_oe_o,
  output logic          irq_o
);
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_wr;
  logic [LINES-1:0] en_q;
  logic [LINES-1:0] sync_lvl;
  logic [LINES-1:0] fall_sel;
  logic [LINES-1:0] evt;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] status;
  logic [LINES-1:0] lvl_rd;
  logic [RW-1:0]    stat_full;
  logic [RW-1:0]    en_full;

  always_comb begin
    ctrl_wr       = ctrl_t'(reg_wdata_i);
    ctrl_wr.spare = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CTRL) ctrl_q <= ctrl_wr;
      if (reg_addr_i == A_IEN)  en_q   <= reg_wdata_i[B_EVT +: LINES];
    end
  end

  assign clr = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i[B_EVT +: LINES] : '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign pad_oe_o[g*GRP +: GRP] = {GRP{ctrl_q.dir[g]}};
  end

  for (genvar i = 0; i < LINES; i++) begin : g_pol
    if (i < GRP) begin : g_own
      assign fall_sel[i] = ctrl_q.lpol[i];
    end else begin : g_shared
      assign fall_sel[i] = ctrl_q.upol;
    end
  end

  assign pad_o = ctrl_q.out;

  dio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync_lvl)
  );

  dio_edge #(.W(LINES), .SETTLE(SYNC_STAGES + 1)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_lvl),
    .fall_i(fall_sel),
    .evt_o (evt)
  );

  dio_irq #(.W(LINES)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (clr),
    .en_i    (en_q),
    .status_o(status),
    .irq_o   (irq_o)
  );

  assign lvl_rd = (pad_oe_o & ctrl_q.out) | (~pad_oe_o & sync_lvl);

  always_comb begin
    stat_full = '0;
    stat_full[B_EVT +: LINES] = status;
    en_full = '0;
    en_full[B_EVT +: LINES] = en_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {ctrl_q.lpol, ctrl_q.dir, 1'b0, ctrl_q.upol, lvl_rd};
      A_STAT:  reg_rdata_o = stat_full;
      A_IEN:   reg_rdata_o = en_full;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dio_port_chk.sv
module dio_port_chk
  import dio_port_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [AW-1:0]    reg_addr_i,
  input logic [RW-1:0]    reg_wdata_i,
  input logic [LINES-1:0] pad_o,
  input logic [LINES-1:0] pad_oe_o,
  input logic             irq_o,
  input logic [RW-1:0]    stat_q,
  input logic [LINES-1:0] en_q,
  input logic [LINES-1:0] evt
);
  logic          ctrl_wr;
  logic [RW-1:0] clr_m;
  logic [RW-1:0] evt_m;

  assign ctrl_wr = reg_we_i && reg_addr_i == A_CTRL;
  assign clr_m   = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i : '0;
  assign evt_m   = RW'(evt) << B_EVT;

  assert_pad_drive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> pad_o == $past(reg_wdata_i[LINES-1:0]));

  for (genvar g = 0; g < NGRP; g++) begin : g_dir
    assert_group_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr |=> pad_oe_o[g*GRP +: GRP] == {GRP{$past(reg_wdata_i[10+g])}});
  end

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(stat_q & ~clr_m) & ~stat_q) == '0);

  assert_event_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ($past(evt_m) & ~stat_q) == '0);

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_m != '0) |=> ($past(clr_m & ~evt_m) & stat_q) == '0);

  assert_irq_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

bind dio_port dio_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .pad_o      (pad_o),
  .pad_oe_o   (pad_oe_o),
  .irq_o      (irq_o),
  .stat_q     (stat_full),
  .en_q       (en_q),
  .evt        (evt)
);

// File: tb/dio_port_tb.sv
module dio_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [7:0]  pad_i = '0;
  logic [7:0]  pad_o;
  logic [7:0]  pad_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl = '0;
  logic [7:0]  m_stat = '0;
  logic [7:0]  m_en = '0;
  logic [7:0]  m_pad = '0;

  always #4 clk_i = ~clk_i;

  dio_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] f_events(logic [7:0] o, logic [7:0] n, logic [15:0] c);
    logic [7:0] ev;
    for (int i = 0; i < 8; i++) begin
      logic fall;
      fall  = (i < 4) ? c[12+i] : c[8];
      ev[i] = fall ? (o[i] & ~n[i]) : (~o[i] & n[i]);
    end
    return ev;
  endfunction

  function automatic logic [7:0] f_oe(logic [15:0] c);
    return {{4{c[11]}}, {4{c[10]}}};
  endfunction

  function automatic logic [15:0] f_ctrl_rd(logic [15:0] c, logic [7:0] p);
    logic [7:0] oe;
    oe = f_oe(c);
    return {c[15:10], 1'b0, c[8], (oe & c[7:0]) | (~oe & p)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    case (a)
      2'd0: m_ctrl = d & 16'hFDFF;
      2'd1: m_stat = m_stat & ~d[15:8];
      2'd2: m_en = d[15:8];
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pad_step(logic [7:0] n);
    @(negedge clk_i);
    pad_i  = n;
    m_stat = m_stat | f_events(m_pad, n, m_ctrl);
    m_pad  = n;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic check_all(string req);
    logic [15:0] d;
    rd(2'd0, d); chk({req, " ctrl"}, d, f_ctrl_rd(m_ctrl, m_pad));
    rd(2'd1, d); chk({req, " status"}, d, {m_stat, 8'h00});
    rd(2'd2, d); chk({req, " enable"}, d, {m_en, 8'h00});
    chk({req, " irq"}, {15'd0, irq_o}, {15'd0, |(m_stat & m_en)});
    chk({req, " pad_o"}, {8'd0, pad_o}, {8'd0, m_ctrl[7:0]});
    chk({req, " pad_oe"}, {8'd0, pad_oe_o}, {8'd0, f_oe(m_ctrl)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R10 reset state
    check_all("R10");

    // R1 R2 R3: low nibble output
    wr(2'd0, 16'h04A5);
    chk("R1 pad_o", {8'd0, pad_o}, 16'h00A5);
    chk("R2 pad_oe", {8'd0, pad_oe_o}, 16'h000F);
    rd(2'd0, d); chk("R3 ctrl read mixed", d, 16'h0405);

    // R5 R3: rising on lines 4,5
    pad_step(8'h30);
    rd(2'd0, d); chk("R3 input levels", d, 16'h0435);
    rd(2'd1, d); chk("R5 status set", d, 16'h3000);
    chk("R8 irq masked", {15'd0, irq_o}, 16'd0);

    // R8 enable masking
    wr(2'd2, 16'h1000);
    chk("R8 irq enabled", {15'd0, irq_o}, 16'd1);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); chk("R8 enable low byte zero", d, 16'hFF00);
    wr(2'd2, 16'h0000);
    chk("R8 irq off", {15'd0, irq_o}, 16'd0);

    // R6 write-one clear
    wr(2'd1, 16'h1000);
    rd(2'd1, d); chk("R6 partial clear", d, 16'h2000);
    wr(2'd1, 16'h00FF);
    rd(2'd1, d); chk("R6 zeros ignored", d, 16'h2000);

    // R9 edge on an output line
    pad_step(8'h31);
    rd(2'd1, d); chk("R9 event on output line", d, 16'h2100);
    wr(2'd1, 16'hFFFF);

    // R4 per-line falling on line 0
    wr(2'd0, 16'h1000);
    pad_step(8'h30);
    rd(2'd1, d); chk("R4 line0 falling", d, 16'h0100);
    pad_step(8'h31);
    rd(2'd1, d); chk("R4 line0 rising ignored", d, 16'h0100);
    // R4 shared falling for upper nibble
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h0100);
    pad_step(8'h01);
    rd(2'd1, d); chk("R4 upper falling", d, 16'h3000);
    pad_step(8'h81);
    rd(2'd1, d); chk("R4 upper rising ignored", d, 16'h3000);
    wr(2'd1, 16'hFFFF);

    // R7 event and clear in the same cycle on line 2
    wr(2'd0, 16'h0000);
    pad_step(8'h85);
    rd(2'd1, d); chk("R7 setup", d, 16'h0400);
    pad_step(8'h81);
    @(negedge clk_i);
    pad_i = 8'h85;
    @(negedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 16'h0400;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    m_pad = 8'h85;
    m_stat = 8'h04;
    repeat (2) @(negedge clk_i);
    rd(2'd1, d); chk("R7 event wins", d, 16'h0400);
    wr(2'd1, 16'h0400);
    rd(2'd1, d); chk("R6 plain clear", d, 16'h0000);

    // R11 unused address
    wr(2'd0, 16'hC8AA);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); chk("R11 read zero", d, 16'h0000);
    check_all("R11");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: wr(2'd0, 16'($urandom));
        1: wr(2'd2, 16'($urandom));
        2: wr(2'd1, 16'($urandom));
        default: pad_step(8'($urandom));
      endcase
      check_all("R3 R4 R5 R6 R8 random");
    end

    finish_run();
  end
endmodule